// File: doc/BRIEF.md
# Column-In Row-Out Transpose Buffer

This block sits between the two one-dimensional passes of a separable 2D transform. It is built from registers only. It holds an N×N tile of coefficients in an array of registers. The first pass delivers the tile one column at a time: each accepted column vector fills one column of the array, and the columns fill in order from 0 to N-1. A write counter drives a one-hot column enable that picks the column.

Once the N-th column has been accepted, the buffer is full and stops taking writes. The second pass then asks for rows with a read request. On each request, row-select multiplexers place one whole row on a registered output with a one-cycle valid strobe, and the rows come out in order from 0 to N-1. The read that returns the last row empties the buffer, and column writes resume.

The column input is a valid/ready stream. A column is transferred in a cycle where `col_valid` and `col_ready` are both high. `col_ready` is low for the whole time the buffer is full, and a producer must hold its column until it sees ready. The read side has no back-pressure: each accepted request yields exactly one row, with `row_valid` high for one cycle.

Top module: `tpose_buf`

## Requirements
- R1: After reset, `full` is 0, `col_ready` is 1, `row_valid` is 0 and `row_data` is all zeros.
- R2: An accepted column write stores element r of `col_data` (bits r*W to r*W+W-1) into row r of the current column. Successive accepted writes fill columns 0, 1, …, N-1 in order.
- R3: The edge that accepts the N-th column write sets `full` to 1 and `col_ready` to 0. Before that edge, `full` stays 0.
- R4: A column offered while `col_ready` is 0 is ignored: the rows read out afterwards hold the previously stored tile.
- R5: A read request while `full` is 0 is ignored. It produces no `row_valid` and does not advance the row order.
- R6: A read request while `full` is 1 raises `row_valid` for exactly the next cycle. In that cycle, element c of `row_data` (bits c*W to c*W+W-1) is the value in column c of the current row. Rows are returned in order 0 to N-1.
- R7: The edge that accepts the N-th read clears `full` and raises `col_ready`. The next tile's writes start again at column 0.
- R8: Cycles with `col_valid` low between writes store nothing and do not disturb the column order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_data | input | N*W | Column vector from the first pass, element r in bits r*W+:W |
| col_valid | input | 1 | Column vector is offered |
| col_ready | output | 1 | Buffer accepts a column (low while full) |
| rd_req | input | 1 | Request for the next row |
| row_data | output | N*W | Registered row vector, element c in bits c*W+:W |
| row_valid | output | 1 | `row_data` carries a new row this cycle |
| full | output | 1 | The whole tile is held and is ready to be read out |

## Verification
Faults in the write counter or the column enables show up as values in the wrong places in the rows read back. The mismatch is visible in the very first row of the tile. A fault in the fill or drain state shows as `full` or `col_ready` changing one edge early or late, so every tile checks both flags right after its N-th write and its N-th read. A faulty read counter returns rows out of order or repeats a row, and the row-by-row comparison flags it at the first row that differs. Ignored writes and ignored reads are checked by reading the whole tile back after the stimulus.

// File: rtl/tpose_pkg.sv
package tpose_pkg;
  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tpose_ctrl.sv
module tpose_ctrl
  import tpose_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  col_valid,
  input  logic                  rd_req,
  output logic [N-1:0]          col_en,
  output logic                  rd_fire,
  output logic [idx_w(N)-1:0]   rd_row,
  output logic                  full
);
  localparam int IW = idx_w(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  phase_t        phase;
  logic [IW-1:0] wcnt;
  logic [IW-1:0] rcnt;
  logic          wr_fire;

  assign full    = (phase == PH_DRAIN);
  assign wr_fire = col_valid && (phase == PH_FILL);
  assign rd_fire = rd_req && (phase == PH_DRAIN);
  assign rd_row  = rcnt;

  for (genvar k = 0; k < N; k++) begin : g_en
    assign col_en[k] = wr_fire && (wcnt == IW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FILL;
      wcnt  <= '0;
      rcnt  <= '0;
    end else begin
      if (wr_fire) begin
        if (wcnt == LAST) begin
          wcnt  <= '0;
          phase <= PH_DRAIN;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
      if (rd_fire) begin
        if (rcnt == LAST) begin
          rcnt  <= '0;
          phase <= PH_FILL;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  // R2
  col_en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_en));

  // R3
  fill_to_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($past(col_valid) && $past(col_en[N-1])));

  // R5
  no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && rd_req) |=> $stable(rcnt));
endmodule

// File: rtl/tpose_array.sv
module tpose_array #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       col_en,
  input  logic [N*W-1:0]     col_data,
  output logic [N*N*W-1:0]   cells
);
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cells[(r*N+c)*W +: W] <= '0;
        else if (col_en[c])
          cells[(r*N+c)*W +: W] <= col_data[r*W +: W];
      end
    end
  end

  // R4 R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|col_en) |=> $stable(cells));
endmodule

// File: rtl/tpose_rowmux.sv
module tpose_rowmux
  import tpose_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N*N*W-1:0]     cells,
  input  logic                 rd_fire,
  input  logic [idx_w(N)-1:0]  rd_row,
  output logic [N*W-1:0]       row_data,
  output logic                 row_valid
);
  logic [N*W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int c = 0; c < N; c++)
      sel[c*W +: W] = cells[(int'(rd_row)*N + c)*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_valid <= 1'b0;
      row_data  <= '0;
    end else begin
      row_valid <= rd_fire;
      if (rd_fire) row_data <= sel;
    end
  end

  // R6
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_valid |-> $stable(row_data) || $past(!rst_n));
endmodule

// File: rtl/tpose_buf.sv
module tpose_buf
  import tpose_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N*W-1:0]   col_data,
  input  logic             col_valid,
  output logic             col_ready,
  input  logic             rd_req,
  output logic [N*W-1:0]   row_data,
  output logic             row_valid,
  output logic             full
);
  localparam int IW = idx_w(N);

  logic [N-1:0]     col_en;
  logic             rd_fire;
  logic [IW-1:0]    rd_row;
  logic [N*N*W-1:0] cells;

  tpose_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .rd_req(rd_req),
    .col_en(col_en), .rd_fire(rd_fire), .rd_row(rd_row), .full(full)
  );

  tpose_array #(.N(N), .W(W)) u_array (
    .clk(clk), .rst_n(rst_n), .col_en(col_en), .col_data(col_data),
    .cells(cells)
  );

  tpose_rowmux #(.N(N), .W(W)) u_mux (
    .clk(clk), .rst_n(rst_n), .cells(cells), .rd_fire(rd_fire),
    .rd_row(rd_row), .row_data(row_data), .row_valid(row_valid)
  );

  assign col_ready = !full;

  // R6
  row_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> ($past(full) && $past(rd_req)));

  // R7
  drain_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> ($past(rd_req) && row_valid));
endmodule

// File: tb/tb_tpose_buf.sv
`timescale 1ns/1ps
module tb_tpose_buf;
  localparam int N = 4;
  localparam int W = 16;

  // {seed[15:0], write gap[3:0], read gap[3:0]}
  localparam int NV = 4;
  localparam logic [23:0] VEC [NV] = '{
    {16'h0100, 4'd0, 4'd0},
    {16'h2A55, 4'd1, 4'd0},
    {16'hF00D, 4'd0, 4'd2},
    {16'h7FF0, 4'd3, 4'd1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*W-1:0] col_data = '0;
  logic           col_valid = 1'b0;
  logic           col_ready;
  logic           rd_req = 1'b0;
  logic [N*W-1:0] row_data;
  logic           row_valid;
  logic           full;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tpose_buf #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .col_data(col_data), .col_valid(col_valid),
    .col_ready(col_ready), .rd_req(rd_req), .row_data(row_data),
    .row_valid(row_valid), .full(full)
  );

  function automatic logic [W-1:0] elem(input logic [15:0] seed, input int r, input int c);
    return W'(seed + 16'(r*37) + 16'(c*5) + 16'(r*c*11));
  endfunction

  function automatic logic [N*W-1:0] col_vec(input logic [15:0] seed, input int c);
    logic [N*W-1:0] v;
    for (int r = 0; r < N; r++) v[r*W +: W] = elem(seed, r, c);
    return v;
  endfunction

  function automatic logic [N*W-1:0] row_vec(input logic [15:0] seed, input int r);
    logic [N*W-1:0] v;
    for (int c = 0; c < N; c++) v[c*W +: W] = elem(seed, r, c);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(input logic [15:0] seed, input int gap);
    for (int c = 0; c < N; c++) begin
      col_data  = col_vec(seed, c);
      col_valid = 1'b1;
      @(negedge clk);
      col_valid = 1'b0;
      if (c < N-1) chk(full == 1'b0, "R3 not full early", 64'(full), 64'd0);
      idle(gap);
    end
  endtask

  task automatic drain(input logic [15:0] seed, input int gap);
    for (int r = 0; r < N; r++) begin
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk(row_valid == 1'b1, "R6 row_valid", 64'(row_valid), 64'd1);
      chk(row_data == row_vec(seed, r), "R2 R6 row data", 64'(row_data), 64'(row_vec(seed, r)));
      @(negedge clk);
      chk(row_valid == 1'b0, "R6 single strobe", 64'(row_valid), 64'd0);
      idle(gap);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    idle(2);
    chk(full == 1'b0, "R1 full", 64'(full), 64'd0);
    chk(col_ready == 1'b1, "R1 col_ready", 64'(col_ready), 64'd1);
    chk(row_valid == 1'b0, "R1 row_valid", 64'(row_valid), 64'd0);
    chk(row_data == '0, "R1 row_data", 64'(row_data), 64'd0);
    rst_n = 1'b1;
    idle(1);

    // table walk: R2 R3 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      fill(VEC[i][23:8], int'(VEC[i][7:4]));
      chk(full == 1'b1, "R3 full set", 64'(full), 64'd1);
      chk(col_ready == 1'b0, "R3 ready low", 64'(col_ready), 64'd0);
      drain(VEC[i][23:8], int'(VEC[i][3:0]));
      chk(full == 1'b0, "R7 full cleared", 64'(full), 64'd0);
      chk(col_ready == 1'b1, "R7 ready back", 64'(col_ready), 64'd1);
    end

    // R4: writes offered while full are dropped
    fill(16'h1234, 0);
    col_data  = col_vec(16'hDEAD, 0);
    col_valid = 1'b1;
    idle(3);
    col_valid = 1'b0;
    chk(col_ready == 1'b0, "R4 ready low while full", 64'(col_ready), 64'd0);
    drain(16'h1234, 0);

    // R5: reads while empty are dropped and do not skip rows
    rd_req = 1'b1;
    @(negedge clk);
    chk(row_valid == 1'b0, "R5 no strobe when empty", 64'(row_valid), 64'd0);
    @(negedge clk);
    rd_req = 1'b0;
    chk(row_valid == 1'b0, "R5 no strobe when empty 2", 64'(row_valid), 64'd0);
    fill(16'h5A5A, 0);
    drain(16'h5A5A, 0);

    // R1: mid-operation reset returns to empty
    fill(16'h0F0F, 0);
    rst_n = 1'b0;
    idle(1);
    chk(full == 1'b0, "R1 reset clears full", 64'(full), 64'd0);
    rst_n = 1'b1;
    idle(1);
    fill(16'h3C3C, 1);
    drain(16'h3C3C, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule